// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This unit multiplies two 32-bit operands and combines the 64-bit product with an accumulator that is held as two 32-bit halves, HI (upper) and LO (lower). Four arithmetic kinds are available: plain multiply, negated multiply, multiply-add and multiply-subtract. Each kind can treat its operands as signed or as unsigned. Every operation writes the new 64-bit value back into HI:LO. It also returns one half of that new value as a 32-bit result for the general register file, and an opcode bit chooses which half.

Operations enter through a valid/ready handshake. An operation is accepted on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` then stays low for the fixed latency of the multiplier, so a source has to hold `op_valid` and its opcode and operands steady until it sees `op_ready` high. The result side has no back-pressure: `res_done` pulses for one cycle and `res_data` is valid in that cycle. The HI and LO registers can be read at any time and written directly through their own write-enable ports.

Top module: `hilo_mac`

## Requirements
- R1: After reset, HI and LO read as zero, `res_done` is low and `op_ready` is high.
- R2: The opcode is 4 bits. Bit 3 picks the returned half (1 = new HI, 0 = new LO). Bits 2:1 pick the kind (00 multiply, 01 negated multiply, 10 multiply-add, 11 multiply-subtract). Bit 0 set means the operands are unsigned.
- R3: An accepted operation drives `op_ready` low. `res_done` pulses high for exactly one cycle, and that pulse is visible after the LATENCY-th (default 4) clock edge that follows the accepting edge. `op_ready` is high again in that same cycle. An operation presented while `op_ready` is low is not taken.
- R4: Plain multiply writes the 64-bit product into HI:LO.
- R5: Negated multiply writes zero minus the product into HI:LO.
- R6: Multiply-add writes the previous HI:LO plus the product.
- R7: Multiply-subtract writes the previous HI:LO minus the product.
- R8: `res_data` equals the half of the new HI:LO that bit 3 selects. HI and LO show their new values in the same cycle as `res_done`.
- R9: A direct write to HI or LO lands on the next edge when no operation is in flight. While an operation is in flight, including its completion cycle, direct writes are ignored.
- R10: All arithmetic wraps modulo 2^64 and no overflow indication exists.
- R11: Signed kinds sign-extend both operands to 64 bits before multiplying. Unsigned kinds zero-extend them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation |
| op_code | input | 4 | Half select, kind, unsigned flag |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| res_done | output | 1 | One-cycle completion strobe |
| res_data | output | 32 | Selected half of the new accumulator |
| hi_wr_en | input | 1 | Direct write of HI |
| hi_wr_data | input | 32 | Data for HI |
| lo_wr_en | input | 1 | Direct write of LO |
| lo_wr_data | input | 32 | Data for LO |
| hi_rd | output | 32 | Current HI |
| lo_rd | output | 32 | Current LO |

## Verification
The assertions check the following on every cycle: an accepted operation drops `op_ready`, the completion strobe comes exactly LATENCY edges after acceptance and lasts one cycle, HI and LO hold still while an operation is in flight, the result always matches one of the two accumulator halves, and an idle direct write lands. The arithmetic itself can only be shown by the bench scenarios. These cover sign- against zero-extension of the same operand bits, each of the four kinds with both returned halves, accumulation across a chain of operations, wrap-around at 2^64, and direct writes that are applied when idle or dropped while busy.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;
  localparam int OP_W = 4;

  typedef enum logic [1:0] {
    K_MUL = 2'b00,
    K_NEG = 2'b01,
    K_ADD = 2'b10,
    K_SUB = 2'b11
  } mac_kind_e;

  // bit 3: return HI, bits 2:1: kind, bit 0: unsigned operands
  typedef struct packed {
    logic      hi_sel;
    mac_kind_e kind;
    logic      unsgn;
  } mac_op_t;
endpackage

// File: rtl/hilo_mac_seq.sv
module hilo_mac_seq #(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_valid,
  output logic op_ready,
  output logic accept,
  output logic fire,
  output logic res_done
);
  localparam int CNT_W = $clog2(LATENCY + 1) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy;

  assign busy     = (cnt_q != '0);
  assign op_ready = !busy;
  assign accept   = op_valid && !busy;
  assign fire     = busy && (cnt_q == CNT_W'(LATENCY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      res_done <= 1'b0;
    end else begin
      res_done <= fire;
      if (accept)     cnt_q <= CNT_W'(1);
      else if (fire)  cnt_q <= '0;
      else if (busy)  cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/hilo_mac_alu.sv
module hilo_mac_alu
  import hilo_mac_pkg::*;
#(
  parameter int W = 32
) (
  input  mac_kind_e        kind,
  input  logic             unsgn,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [2*W-1:0]   acc,
  output logic [2*W-1:0]   nxt
);
  localparam int AW = 2 * W;

  logic [W-1:0]  opnd [2];
  logic [AW-1:0] ext  [2];
  logic [AW-1:0] prod;

  assign opnd[0] = a;
  assign opnd[1] = b;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    assign ext[g] = unsgn ? {{W{1'b0}}, opnd[g]}
                          : {{W{opnd[g][W-1]}}, opnd[g]};
  end

  assign prod = ext[0] * ext[1];

  always_comb begin
    unique case (kind)
      K_MUL:   nxt = prod;
      K_NEG:   nxt = '0 - prod;
      K_ADD:   nxt = acc + prod;
      default: nxt = acc - prod;
    endcase
  end
endmodule

// File: rtl/hilo_mac_acc.sv
module hilo_mac_acc
  import hilo_mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             fire,
  input  logic             busy,
  input  logic [OP_W-1:0]  op_code,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [2*W-1:0]   nxt,
  input  logic             hi_wr_en,
  input  logic [W-1:0]     hi_wr_data,
  input  logic             lo_wr_en,
  input  logic [W-1:0]     lo_wr_data,
  output mac_op_t          op_q,
  output logic [W-1:0]     a_q,
  output logic [W-1:0]     b_q,
  output logic [W-1:0]     hi_q,
  output logic [W-1:0]     lo_q,
  output logic [W-1:0]     res_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      res_q <= '0;
    end else begin
      if (accept) begin
        op_q <= mac_op_t'(op_code);
        a_q  <= op_a;
        b_q  <= op_b;
      end
      if (fire) begin
        hi_q  <= nxt[2*W-1:W];
        lo_q  <= nxt[W-1:0];
        res_q <= op_q.hi_sel ? nxt[2*W-1:W] : nxt[W-1:0];
      end else if (!busy) begin
        if (hi_wr_en) hi_q <= hi_wr_data;
        if (lo_wr_en) lo_q <= lo_wr_data;
      end
    end
  end
endmodule

// File: rtl/hilo_mac.sv
module hilo_mac
  import hilo_mac_pkg::*;
#(
  parameter int W       = 32,
  parameter int LATENCY = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [OP_W-1:0] op_code,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  output logic            res_done,
  output logic [W-1:0]    res_data,
  input  logic            hi_wr_en,
  input  logic [W-1:0]    hi_wr_data,
  input  logic            lo_wr_en,
  input  logic [W-1:0]    lo_wr_data,
  output logic [W-1:0]    hi_rd,
  output logic [W-1:0]    lo_rd
);
  logic           accept, fire;
  mac_op_t        op_q;
  logic [W-1:0]   a_q, b_q;
  logic [2*W-1:0] nxt;

  hilo_mac_seq #(.LATENCY(LATENCY)) seq_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .accept(accept), .fire(fire), .res_done(res_done)
  );

  hilo_mac_alu #(.W(W)) alu_i (
    .kind(op_q.kind), .unsgn(op_q.unsgn), .a(a_q), .b(b_q),
    .acc({hi_rd, lo_rd}), .nxt(nxt)
  );

  hilo_mac_acc #(.W(W)) acc_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .fire(fire), .busy(!op_ready),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .nxt(nxt),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .op_q(op_q), .a_q(a_q), .b_q(b_q), .hi_q(hi_rd), .lo_q(lo_rd), .res_q(res_data)
  );
endmodule

// File: rtl/hilo_mac_chk.sv
module hilo_mac_chk #(
  parameter int W       = 32,
  parameter int LATENCY = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_ready,
  input logic         res_done,
  input logic [W-1:0] res_data,
  input logic         hi_wr_en,
  input logic [W-1:0] hi_wr_data,
  input logic [W-1:0] hi_rd,
  input logic [W-1:0] lo_rd
);
  localparam int CW = $clog2(LATENCY + 2) + 1;
  logic [CW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n) since_q <= '0;
    else if (op_valid && op_ready) since_q <= CW'(1);
    else if (res_done) since_q <= '0;
    else if (since_q != '0) since_q <= since_q + CW'(1);
  end

  a_r3_drop_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> !op_ready);
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);
  a_r3_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> op_ready);
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (since_q == CW'(LATENCY + 1)));
  a_r8_result_half: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (res_data == hi_rd || res_data == lo_rd));
  a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |=> ($stable(hi_rd) && $stable(lo_rd)) || res_done);
  a_r9_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ready && hi_wr_en) |=> hi_rd == $past(hi_wr_data));
endmodule

bind hilo_mac hilo_mac_chk #(.W(W), .LATENCY(LATENCY)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .res_done(res_done), .res_data(res_data), .hi_wr_en(hi_wr_en),
  .hi_wr_data(hi_wr_data), .hi_rd(hi_rd), .lo_rd(lo_rd)
);

// File: tb/hilo_mac_tb_top.sv
module hilo_mac_tb_top;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic [3:0]    op_code = '0;
  logic [W-1:0]  op_a = '0, op_b = '0;
  logic          res_done;
  logic [W-1:0]  res_data;
  logic          hi_wr_en = 1'b0, lo_wr_en = 1'b0;
  logic [W-1:0]  hi_wr_data = '0, lo_wr_data = '0;
  logic [W-1:0]  hi_rd, lo_rd;

  always #2.5 clk = ~clk;

  hilo_mac dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .res_done(res_done),
    .res_data(res_data), .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data), .hi_rd(hi_rd), .lo_rd(lo_rd)
  );

  typedef struct {
    logic [W-1:0] res;
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  int           n_chk = 0;
  int           n_fail = 0;
  logic [W-1:0] m_hi = '0, m_lo = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [3:0] op, input logic [W-1:0] a,
                                        input logic [W-1:0] b, input logic [63:0] acc);
    logic [63:0] ea, eb, p;
    ea = op[0] ? {32'b0, a} : {{32{a[31]}}, a};
    eb = op[0] ? {32'b0, b} : {{32{b[31]}}, b};
    p  = ea * eb;
    case (op[2:1])
      2'b00:   return p;
      2'b01:   return 64'd0 - p;
      2'b10:   return acc + p;
      default: return acc - p;
    endcase
  endfunction

  // driver: predicts, queues, then offers until accepted
  task automatic issue(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tag);
    logic [63:0] n;
    exp_t e;
    n = model(op, a, b, {m_hi, m_lo});
    m_hi = n[63:32];
    m_lo = n[31:0];
    e.res = op[3] ? m_hi : m_lo;
    e.hi = m_hi;
    e.lo = m_lo;
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    op_valid = 1'b1;
    op_code = op;
    op_a = a;
    op_b = b;
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!op_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && res_done) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R3 unexpected completion", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(res_data == e.res, {"R8 result ", e.tag}, 64'(res_data), 64'(e.res));
        chk(hi_rd == e.hi, {"HI ", e.tag}, 64'(hi_rd), 64'(e.hi));
        chk(lo_rd == e.lo, {"LO ", e.tag}, 64'(lo_rd), 64'(e.lo));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hi_rd == 0 && lo_rd == 0, "R1 HI:LO zero", {hi_rd, lo_rd}, 64'd0);
    chk(op_ready == 1'b1, "R1 ready", 64'(op_ready), 64'd1);
    chk(res_done == 1'b0, "R1 done low", 64'(res_done), 64'd0);

    // R4 R11 R3: signed multiply, return HI, latency measured
    issue(4'b1000, 32'hFFFF_FFFD, 32'd7, "R4 signed mul");
    chk(op_ready == 1'b0, "R3 ready low after accept", 64'(op_ready), 64'd0);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      n++;
      if (res_done) break;
    end
    chk(n == 4, "R3 latency", 64'(n), 64'd4);
    chk(op_ready == 1'b1, "R3 ready with done", 64'(op_ready), 64'd1);
    chk({hi_rd, lo_rd} == 64'hFFFF_FFFF_FFFF_FFEB, "R11 sign extend", {hi_rd, lo_rd},
        64'hFFFF_FFFF_FFFF_FFEB);
    @(negedge clk);
    chk(res_done == 1'b0, "R3 one-cycle done", 64'(res_done), 64'd0);

    // R11 unsigned, same bits, return LO
    issue(4'b0001, 32'hFFFF_FFFD, 32'd7, "R11 unsigned mul");
    wait_idle();
    chk({hi_rd, lo_rd} == 64'h0000_0006_FFFF_FFEB, "R11 zero extend", {hi_rd, lo_rd},
        64'h0000_0006_FFFF_FFEB);

    // R5 negated multiply
    issue(4'b1010, 32'd5, 32'd3, "R5 neg signed");
    wait_idle();
    chk({hi_rd, lo_rd} == 64'hFFFF_FFFF_FFFF_FFF1, "R5 neg signed value", {hi_rd, lo_rd},
        64'hFFFF_FFFF_FFFF_FFF1);
    issue(4'b0011, 32'd2, 32'hFFFF_FFFF, "R5 neg unsigned");
    wait_idle();
    chk({hi_rd, lo_rd} == 64'hFFFF_FFFE_0000_0002, "R5 neg unsigned value", {hi_rd, lo_rd},
        64'hFFFF_FFFE_0000_0002);

    // R9 idle direct write
    @(negedge clk);
    hi_wr_en = 1'b1; hi_wr_data = 32'd0;
    lo_wr_en = 1'b1; lo_wr_data = 32'd100;
    @(negedge clk);
    hi_wr_en = 1'b0; lo_wr_en = 1'b0;
    m_hi = 32'd0; m_lo = 32'd100;
    chk({hi_rd, lo_rd} == 64'd100, "R9 idle write", {hi_rd, lo_rd}, 64'd100);

    // R6 R7 accumulate chain, R3 back-to-back offers
    issue(4'b0100, 32'hFFFF_FFFE, 32'd10, "R6 madd signed");
    issue(4'b1101, 32'hFFFF_FFFF, 32'd2, "R6 madd unsigned");
    issue(4'b1110, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 msub signed");
    issue(4'b0111, 32'd3, 32'd1, "R7 msub unsigned");
    wait_idle();
    chk({hi_rd, lo_rd} == 64'h0000_0002_0000_004A, "R7 chain value", {hi_rd, lo_rd},
        64'h0000_0002_0000_004A);

    // R10 wrap-around both ways
    @(negedge clk);
    hi_wr_en = 1'b1; hi_wr_data = 32'hFFFF_FFFF;
    lo_wr_en = 1'b1; lo_wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    hi_wr_en = 1'b0; lo_wr_en = 1'b0;
    m_hi = 32'hFFFF_FFFF; m_lo = 32'hFFFF_FFFF;
    issue(4'b0101, 32'd1, 32'd1, "R10 wrap up");
    wait_idle();
    chk({hi_rd, lo_rd} == 64'd0, "R10 wrap to zero", {hi_rd, lo_rd}, 64'd0);
    issue(4'b1110, 32'd1, 32'd1, "R10 wrap down");
    wait_idle();
    chk({hi_rd, lo_rd} == 64'hFFFF_FFFF_FFFF_FFFF, "R10 wrap to ones", {hi_rd, lo_rd},
        64'hFFFF_FFFF_FFFF_FFFF);

    // R9 writes ignored while busy
    issue(4'b1000, 32'd6, 32'd7, "R9 busy op");
    hi_wr_en = 1'b1; hi_wr_data = 32'hDEAD_BEEF;
    lo_wr_en = 1'b1; lo_wr_data = 32'hDEAD_BEEF;
    while (!op_ready) @(negedge clk);
    hi_wr_en = 1'b0; lo_wr_en = 1'b0;
    chk({hi_rd, lo_rd} == 64'd42, "R9 busy write ignored", {hi_rd, lo_rd}, 64'd42);

    // R2 R8 plain multiply returning LO vs HI
    issue(4'b0000, 32'h8000_0000, 32'd2, "R2 lo select");
    issue(4'b1000, 32'h8000_0000, 32'd2, "R2 hi select");
    wait_idle();
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R3 all results seen", 64'(sb_q.size()), 64'd0);
    report();
  end
endmodule